// File: doc/BRIEF.md
# Power-Management Event and Timer Block

This block holds a small set of power-management registers beside a free-running counter for the power-management timer. A host reads and writes it over a simple single-cycle bus with a 6-bit offset. Reads are combinational. Writes take effect at the clock edge. The counter advances once per cycle in which `tick_i` is high, and the surrounding logic pulses `tick_i` at the 3.579545 MHz timer rate. Three external event inputs record real-time-clock alarms, power-button presses and global-release events in a status register. The counter records its own half-range crossings in the same register.

The block raises a level system-control interrupt while any of the four status bits is pending and also enabled. Software acknowledges an event by writing 1 to its status bit. A control write that requests sleep with the soft-off sleep type produces a one-cycle power-off request pulse. The sleep-enable bit itself is never held in the control register.

Top module: `pm_event_block`

## Requirements
- R1: The timer is a `TMR_W`-bit up-counter (default 24). It advances by one on each clock edge where `tick_i` is high, holds otherwise, and wraps from all-ones to zero. It reads at offset 0x08 zero-extended to 32 bits.
- R2: Only four offsets are mapped: status at 0x00, enable at 0x02, control at 0x04 and timer at 0x08. Every other offset of the 64 reads as zero. A write to the timer offset does not change the count.
- R3: Status is write-1-to-clear. A 1 written to a status bit clears it, a 0 leaves it unchanged, and writes cannot set any bit.
- R4: `sci_o` goes high one cycle after status AND enable becomes nonzero in any of bits 10 (clock alarm), 8 (power button), 5 (global release) or 0 (timer overflow). It drops one cycle after that condition ends. Other enable bits have no effect on it.
- R5: Status bit 0 sets on the edge where the count reaches the armed target. The target is 2^(TMR_W-1) after reset. Clearing a set bit 0 rearms the target to the next multiple of 2^(TMR_W-1) above the current count, modulo 2^TMR_W.
- R6: Control stores every written bit except bit 13 (sleep enable), which always reads 0.
- R7: `pwroff_req_o` is high for exactly the one cycle after a control write with bit 13 set and sleep type bits 12:10 equal to 0. Any other sleep type, or a write with bit 13 clear, gives no pulse.
- R8: A one-cycle pulse on `rtc_evt_i`, `pwrbtn_evt_i` or `gbl_evt_i` sets status bit 10, 8 or 5 respectively. A set wins over a clear written in the same cycle.
- R9: After reset, status, enable, control, timer, `sci_o` and `pwroff_req_o` are all zero.
- R10: The enable register stores and reads back all 16 written bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Timer advance strobe |
| rtc_evt_i | input | 1 | Clock-alarm event pulse |
| pwrbtn_evt_i | input | 1 | Power-button event pulse |
| gbl_evt_i | input | 1 | Global-release event pulse |
| bus_we_i | input | 1 | Write strobe |
| bus_addr_i | input | 6 | Register offset |
| bus_wdata_i | input | 16 | Write data |
| bus_rdata_o | output | 32 | Read data for `bus_addr_i` |
| sci_o | output | 1 | Level interrupt request |
| pwroff_req_o | output | 1 | Soft power-off request pulse |

## Verification
The hard case to reach is the overflow status. With a 24-bit count, the first half-range crossing takes millions of ticks, and the rearm after a clear depends on where the count sits at that moment. The bench therefore builds the block with a 10-bit timer, so the crossing happens at 512 and the wrap at 1024. It then drives the count to one short of each boundary, checks that no status is set, and steps once more. It also clears at a count above the half point, so the rearmed target wraps through zero.

// File: rtl/pm_evt_pkg.sv
package pm_evt_pkg;
  localparam int REG_W  = 16;
  localparam int ADDR_W = 6;
  localparam int RD_W   = 32;
  localparam int N_SRC  = 4;

  localparam logic [ADDR_W-1:0] OFS_STS = 6'h00;
  localparam logic [ADDR_W-1:0] OFS_EN  = 6'h02;
  localparam logic [ADDR_W-1:0] OFS_CTL = 6'h04;
  localparam logic [ADDR_W-1:0] OFS_TMR = 6'h08;

  localparam int SLP_EN_BIT = 13;
  localparam int SLP_TY_LO  = 10;
  localparam int SLP_TY_W   = 3;

  // source index -> status bit: 0 timer, 1 global, 2 button, 3 alarm
  function automatic int src_pos(input int i);
    case (i)
      0:       return 0;
      1:       return 5;
      2:       return 8;
      default: return 10;
    endcase
  endfunction

  function automatic logic [REG_W-1:0] sci_mask();
    logic [REG_W-1:0] m;
    m = '0;
    for (int i = 0; i < N_SRC; i++) m[src_pos(i)] = 1'b1;
    return m;
  endfunction
endpackage

// File: rtl/pm_acpi_timer.sv
module pm_acpi_timer #(
  parameter int W = 24
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         tick_i,
  input  logic         rearm_i,
  output logic [W-1:0] cnt_o,
  output logic         hit_o
);
  localparam logic [W-1:0] HALF = W'(1) << (W - 1);

  logic [W-1:0] cnt_q, tgt_q, cnt_nxt;
  logic         armed_q;

  assign cnt_nxt = cnt_q + W'(1);
  assign hit_o   = tick_i && armed_q && (cnt_nxt == tgt_q);
  assign cnt_o   = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      tgt_q   <= HALF;
      armed_q <= 1'b1;
    end else begin
      if (tick_i) cnt_q <= cnt_nxt;
      if (rearm_i) begin
        // next half-range boundary strictly above the current count
        tgt_q   <= {~cnt_q[W-1], {(W-1){1'b0}}};
        armed_q <= 1'b1;
      end else if (hit_o) begin
        armed_q <= 1'b0;
      end
    end
  end

  p_tick_inc_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_i |=> cnt_o == $past(cnt_o) + W'(1));
  p_hold_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i |=> $stable(cnt_o));
  p_hit_boundary_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_o |=> cnt_o[W-2:0] == '0);
endmodule

// File: rtl/pm_status_regs.sv
module pm_status_regs
  import pm_evt_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_SRC-1:0] set_i,
  input  logic             we_i,
  input  logic [REG_W-1:0] wdata_i,
  output logic [REG_W-1:0] sts_o
);
  logic [N_SRC-1:0] flag_q;
  logic [N_SRC-1:0] clr;

  for (genvar i = 0; i < N_SRC; i++) begin : g_src
    assign clr[i] = we_i && wdata_i[src_pos(i)];

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       flag_q[i] <= 1'b0;
      else if (set_i[i]) flag_q[i] <= 1'b1;
      else if (clr[i])   flag_q[i] <= 1'b0;
    end

    p_set_wins_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      set_i[i] |=> sts_o[src_pos(i)]);
    p_w1c_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (clr[i] && !set_i[i]) |=> !sts_o[src_pos(i)]);
    p_no_sw_set_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!set_i[i] && !sts_o[src_pos(i)]) |=> !sts_o[src_pos(i)]);
  end

  always_comb begin
    sts_o = '0;
    for (int i = 0; i < N_SRC; i++) sts_o[src_pos(i)] = flag_q[i];
  end
endmodule

// File: rtl/pm_ctrl_reg.sv
module pm_ctrl_reg
  import pm_evt_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [REG_W-1:0] wdata_i,
  output logic [REG_W-1:0] ctl_o,
  output logic             pwroff_o
);
  localparam logic [REG_W-1:0] SLP_MASK = REG_W'(1) << SLP_EN_BIT;

  logic [REG_W-1:0] ctl_q;
  logic             pwroff_q;
  logic             soft_off;

  assign soft_off = wdata_i[SLP_EN_BIT] &&
                    (wdata_i[SLP_TY_LO +: SLP_TY_W] == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctl_q    <= '0;
      pwroff_q <= 1'b0;
    end else begin
      pwroff_q <= we_i && soft_off;
      if (we_i) ctl_q <= wdata_i & ~SLP_MASK;
    end
  end

  assign ctl_o    = ctl_q;
  assign pwroff_o = pwroff_q;

  p_pwroff_src_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pwroff_o |-> $past(we_i) && $past(wdata_i[SLP_EN_BIT]));
  p_ctl_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_i |=> $stable(ctl_o));
endmodule

// File: rtl/pm_event_block.sv
module pm_event_block
  import pm_evt_pkg::*;
#(
  parameter int TMR_W = 24
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              rtc_evt_i,
  input  logic              pwrbtn_evt_i,
  input  logic              gbl_evt_i,
  input  logic              bus_we_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [REG_W-1:0]  bus_wdata_i,
  output logic [RD_W-1:0]   bus_rdata_o,
  output logic              sci_o,
  output logic              pwroff_req_o
);
  localparam logic [REG_W-1:0] SCI_MASK = sci_mask();

  logic [REG_W-1:0] sts, ctl, en_q;
  logic [TMR_W-1:0] tmr_cnt;
  logic             tmr_hit, rearm, sci_q;
  logic             we_sts, we_en, we_ctl;
  logic [N_SRC-1:0] set_vec;

  assign we_sts = bus_we_i && (bus_addr_i == OFS_STS);
  assign we_en  = bus_we_i && (bus_addr_i == OFS_EN);
  assign we_ctl = bus_we_i && (bus_addr_i == OFS_CTL);
  // rearm only when a set overflow flag is acknowledged
  assign rearm  = we_sts && bus_wdata_i[src_pos(0)] && sts[src_pos(0)];

  assign set_vec = {rtc_evt_i, pwrbtn_evt_i, gbl_evt_i, tmr_hit};

  pm_acpi_timer #(.W(TMR_W)) u_tmr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tick_i (tick_i),
    .rearm_i(rearm),
    .cnt_o  (tmr_cnt),
    .hit_o  (tmr_hit)
  );

  pm_status_regs u_sts (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (set_vec),
    .we_i   (we_sts),
    .wdata_i(bus_wdata_i),
    .sts_o  (sts)
  );

  pm_ctrl_reg u_ctl (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (we_ctl),
    .wdata_i (bus_wdata_i),
    .ctl_o   (ctl),
    .pwroff_o(pwroff_req_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q  <= '0;
      sci_q <= 1'b0;
    end else begin
      if (we_en) en_q <= bus_wdata_i;
      sci_q <= |(sts & en_q & SCI_MASK);
    end
  end

  assign sci_o = sci_q;

  always_comb begin
    case (bus_addr_i)
      OFS_STS: bus_rdata_o = RD_W'(sts);
      OFS_EN:  bus_rdata_o = RD_W'(en_q);
      OFS_CTL: bus_rdata_o = RD_W'(ctl);
      OFS_TMR: bus_rdata_o = RD_W'(tmr_cnt);
      default: bus_rdata_o = '0;
    endcase
  end

  p_sci_on_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((sts & en_q & SCI_MASK) != '0) |=> sci_o);
  p_sci_off_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((sts & en_q & SCI_MASK) == '0) |=> !sci_o);
  p_tmr_ro_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_we_i && bus_addr_i == OFS_TMR && !tick_i) |=> $stable(tmr_cnt));
  p_ovf_rise_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sts[src_pos(0)]) |-> tmr_cnt[TMR_W-2:0] == '0);
endmodule

// File: tb/pm_event_block_bench.sv
module pm_event_block_bench;
  localparam int TW = 10;
  localparam logic [TW-1:0] TMASK = '1;

  logic        clk = 1'b0;
  logic        rst_ni, tick, rtc, pwr, gbl, we;
  logic [5:0]  addr;
  logic [15:0] wdata;
  logic [31:0] rdata;
  logic        sci, pwroff;

  int total = 0;
  int bad   = 0;
  bit done  = 0;
  int cnt_m = 0;

  always #10 clk = ~clk;

  pm_event_block #(.TMR_W(TW)) u_pm_event_block (
    .clk_i(clk), .rst_ni(rst_ni), .tick_i(tick),
    .rtc_evt_i(rtc), .pwrbtn_evt_i(pwr), .gbl_evt_i(gbl),
    .bus_we_i(we), .bus_addr_i(addr), .bus_wdata_i(wdata),
    .bus_rdata_o(rdata), .sci_o(sci), .pwroff_req_o(pwroff)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [15:0] d);
    @(negedge clk);
    addr = a; wdata = d; we = 1'b1;
    @(posedge clk);
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] v);
    addr = a;
    #1 v = rdata;
  endtask

  task automatic ticks(input int n);
    @(negedge clk);
    tick = 1'b1;
    repeat (n) @(posedge clk);
    @(negedge clk);
    tick = 1'b0;
    cnt_m = (cnt_m + n) % (1 << TW);
  endtask

  task automatic ev(input logic [2:0] m);
    @(negedge clk);
    {rtc, pwr, gbl} = m;
    @(posedge clk);
    @(negedge clk);
    {rtc, pwr, gbl} = 3'b000;
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    logic [15:0] en, d, exp;
    rst_ni = 1'b0; tick = 0; rtc = 0; pwr = 0; gbl = 0; we = 0; addr = '0; wdata = '0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_ni = 1'b1;

    // R9 reset state
    rd(6'h00, v); chk("R9 status", v, 0);
    rd(6'h02, v); chk("R9 enable", v, 0);
    rd(6'h04, v); chk("R9 control", v, 0);
    rd(6'h08, v); chk("R9 timer", v, 0);
    chk("R9 sci", 32'(sci), 0);
    chk("R9 pwroff", 32'(pwroff), 0);

    // R10 enable readback
    foreach (en[i]) ;
    for (int k = 0; k < 5; k++) begin
      d = (k == 0) ? 16'hFFFF : (k == 1) ? 16'h0000 : (k == 2) ? 16'hA5A5 :
          (k == 3) ? 16'h5A5A : 16'h1234;
      wr(6'h02, d);
      rd(6'h02, v); chk("R10 enable readback", v, 32'(d));
    end
    wr(6'h02, 16'h0000);

    // R6 / R7 sleep type sweep
    for (int t = 0; t < 8; t++) begin
      d = 16'(t << 10) | 16'h2000 | 16'h0055;
      wr(6'h04, d);
      chk("R7 pwroff pulse", 32'(pwroff), (t == 0) ? 1 : 0);
      rd(6'h04, v); chk("R6 sleep enable not stored", v, 32'(d & 16'hDFFF));
      @(negedge clk);
      chk("R7 pulse width", 32'(pwroff), 0);
    end
    wr(6'h04, 16'h0000);
    chk("R7 no pulse without sleep enable", 32'(pwroff), 0);
    wr(6'h04, 16'hFFFF);
    rd(6'h04, v); chk("R6 all other bits stored", v, 32'h0000DFFF);
    chk("R7 type 7 no pulse", 32'(pwroff), 0);

    // R2 offset sweep
    wr(6'h02, 16'hA5A5);
    wr(6'h04, 16'h0321);
    ticks(7);
    wr(6'h08, 16'hFFFF);
    for (int a = 0; a < 64; a++) begin
      rd(6'(a), v);
      exp = (a == 0) ? 16'h0 : (a == 2) ? 16'hA5A5 : (a == 4) ? 16'h0321 : 16'h0;
      if (a == 8) chk("R2 timer offset, write ignored, R1 count", v, 32'(cnt_m));
      else        chk("R2 offset decode", v, 32'(exp));
    end
    wr(6'h02, 16'h0000);

    // R8 events set status
    ev(3'b100);
    rd(6'h00, v); chk("R8 alarm event", v, 32'h0400);
    ev(3'b011);
    rd(6'h00, v); chk("R8 button and global events", v, 32'h0520);

    // R4 enable sweep over the four interrupt bits, with unrelated bits set
    for (int e = 0; e < 16; e++) begin
      en = 16'h4002;
      if (e[0]) en[0]  = 1'b1;
      if (e[1]) en[5]  = 1'b1;
      if (e[2]) en[8]  = 1'b1;
      if (e[3]) en[10] = 1'b1;
      wr(6'h02, en);
      @(negedge clk);
      chk("R4 sci level", 32'(sci), ((en & 16'h0520) != 0) ? 1 : 0);
    end
    wr(6'h02, 16'h0000);

    // R3 write-1-to-clear
    wr(6'h00, 16'h0100);
    rd(6'h00, v); chk("R3 clear button only", v, 32'h0420);
    wr(6'h00, 16'hFADF);
    rd(6'h00, v); chk("R3 zeros leave bits", v, 32'h0420);
    wr(6'h00, 16'h0020);
    rd(6'h00, v); chk("R3 clear global", v, 32'h0400);

    // R8 set beats same-cycle clear
    @(negedge clk);
    rtc = 1'b1; addr = 6'h00; wdata = 16'h0400; we = 1'b1;
    @(posedge clk);
    @(negedge clk);
    rtc = 1'b0; we = 1'b0;
    rd(6'h00, v); chk("R8 set wins over clear", v, 32'h0400);
    wr(6'h00, 16'h0400);
    rd(6'h00, v); chk("R3 clear alarm", v, 32'h0000);

    // R5 overflow at first half boundary
    wr(6'h02, 16'h0001);
    ticks(511 - cnt_m);
    rd(6'h08, v); chk("R1 count before boundary", v, 32'(511));
    rd(6'h00, v); chk("R5 no overflow before boundary", v, 0);
    ticks(1);
    rd(6'h00, v); chk("R5 overflow at boundary", v, 32'h0001);
    rd(6'h08, v); chk("R1 count at boundary", v, 32'(512));
    chk("R4 sci lags status", 32'(sci), 0);
    @(negedge clk);
    chk("R4 sci after overflow", 32'(sci), 1);

    // R5 rearm above half point wraps through zero
    ticks(88);
    wr(6'h00, 16'h0001);
    rd(6'h00, v); chk("R5 cleared", v, 0);
    ticks(1023 - cnt_m);
    rd(6'h00, v); chk("R5 no overflow before wrap", v, 0);
    ticks(1);
    rd(6'h08, v); chk("R1 wrap to zero", v, 32'(cnt_m & TMASK));
    rd(6'h00, v); chk("R5 overflow at wrap", v, 32'h0001);
    @(negedge clk);
    chk("R4 sci set again", 32'(sci), 1);

    // R5 rearm below half point targets 512
    ticks(100);
    wr(6'h00, 16'h0001);
    ticks(411);
    rd(6'h00, v); chk("R5 no early set", v, 0);
    ticks(1);
    rd(6'h00, v); chk("R5 set at 512 after rearm", v, 32'h0001);
    wr(6'h00, 16'h0001);
    @(negedge clk);
    @(negedge clk);
    chk("R4 sci drops after clear", 32'(sci), 0);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule